// File: doc/BRIEF.md
# Shared Add/Multiply Arithmetic Unit

This block evaluates one of sixteen arithmetic functions on four signed 16-bit operands. It has a single adder and a single multiplier. A 4-bit control word picks the function. Each control bit drives one multiplexer. One bit picks the first operand and one picks the second. A third bit chooses the sum or the product. The fourth bit decides whether that value is clamped to the signed 16-bit range or passed through as its low 16 bits.

The chosen result is captured in an output register on the clock edge where `in_valid` is high. `out_valid` is high for the following cycle. When `in_valid` is low, the register keeps its last value. A new operation may be presented on every cycle.

Top module: `shared_arith_unit`

## Requirements
- R1: Control bit 0 picks the first kernel operand: `opnd_a` when 0, `opnd_b` when 1.
- R2: Control bit 1 picks the second kernel operand: `opnd_c` when 0, `opnd_d` when 1.
- R3: Control bit 2 picks the kernel output: the sum when 0, the product when 1.
- R4: With control bit 3 at 0 and the sum selected, the result is the low 16 bits of the 17-bit signed sum. It wraps on overflow, so 0x7FFF + 0x0001 gives 0x8000.
- R5: With control bit 3 at 0 and the product selected, the result is the low 16 bits of the 32-bit signed product. For example, 0x0100 * 0x0100 gives 0x0000.
- R6: With control bit 3 at 1, a selected value above 32767 gives 0x7FFF and a value below -32768 gives 0x8000. A value within that range is output unchanged.
- R7: On a rising edge with `in_valid` high, `result` loads the selected value and `out_valid` goes high for the next cycle. On an edge with `in_valid` low, `out_valid` goes low and `result` holds its value.
- R8: A rising edge with `rst` high clears `result` to 0 and `out_valid` to 0, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| ctrl | input | 4 | Function select: [0] A/B, [1] C/D, [2] add/multiply, [3] raw/saturate |
| opnd_a | input | 16 | Signed operand A |
| opnd_b | input | 16 | Signed operand B |
| opnd_c | input | 16 | Signed operand C |
| opnd_d | input | 16 | Signed operand D |
| result | output | 16 | Registered signed result |
| out_valid | output | 1 | High for the cycle after an accepted operation |

## Verification
Every result appears one rising edge after its operands and control are presented. The `result` and `out_valid` registers are the only storage on the path. The bench therefore changes inputs on a falling edge and reads the outputs on the next falling edge. That read point is half a period after the capturing edge, so one vector can be checked on each cycle while the next is applied. For the hold, idle and reset cases, the bench waits one edge and reads both outputs at the next falling edge.

// File: rtl/sau_pkg.sv
package sau_pkg;

  // Decoded view of the 4-bit function select word (MSB first).
  typedef struct packed {
    logic sat_en;   // bit 3: clamp to signed range
    logic use_mul;  // bit 2: multiplier output instead of adder output
    logic pick_d;   // bit 1: second operand from D
    logic pick_b;   // bit 0: first operand from B
  } sau_ctrl_t;

  localparam int unsigned CTRL_W = $bits(sau_ctrl_t);

endpackage

// File: rtl/sau_opsel.sv
module sau_opsel #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             pick_b,
  input  logic             pick_d,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  input  logic [WIDTH-1:0] in_d,
  output logic [WIDTH-1:0] op_x,
  output logic [WIDTH-1:0] op_y
);

  localparam int unsigned LANES = 2;

  logic [LANES-1:0]            lane_sel;
  logic [LANES-1:0][WIDTH-1:0] lane_lo;
  logic [LANES-1:0][WIDTH-1:0] lane_hi;
  logic [LANES-1:0][WIDTH-1:0] lane_out;

  assign lane_sel = {pick_d, pick_b};
  assign lane_lo  = {in_c, in_a};
  assign lane_hi  = {in_d, in_b};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_out[g] = lane_sel[g] ? lane_hi[g] : lane_lo[g];
  end

  assign op_x = lane_out[0];
  assign op_y = lane_out[1];

  always_comb begin
    if (!$isunknown({pick_b, pick_d, in_a, in_b, in_c, in_d})) begin
      AST_OPX_SOURCE: assert (op_x == in_a || op_x == in_b) else $error("op_x from no source"); // R1
      AST_OPY_SOURCE: assert (op_y == in_c || op_y == in_d) else $error("op_y from no source"); // R2
    end
  end

endmodule

// File: rtl/sau_kernel.sv
module sau_kernel #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SUM_W  = WIDTH + 1,
  parameter int unsigned PROD_W = 2 * WIDTH
) (
  input  logic [WIDTH-1:0]  op_x,
  input  logic [WIDTH-1:0]  op_y,
  output logic [SUM_W-1:0]  sum,
  output logic [PROD_W-1:0] prod
);

  logic signed [SUM_W-1:0]  x_ext;
  logic signed [SUM_W-1:0]  y_ext;
  logic signed [PROD_W-1:0] prod_s;

  // The single adder, one guard bit wide.
  assign x_ext = $signed({op_x[WIDTH-1], op_x});
  assign y_ext = $signed({op_y[WIDTH-1], op_y});
  assign sum   = x_ext + y_ext;

  // The single signed multiplier.
  assign prod_s = $signed(op_x) * $signed(op_y);
  assign prod   = prod_s;

endmodule

// File: rtl/sau_post.sv
module sau_post #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SUM_W  = WIDTH + 1,
  parameter int unsigned PROD_W = 2 * WIDTH
) (
  input  logic              use_mul,
  input  logic              sat_en,
  input  logic [SUM_W-1:0]  sum,
  input  logic [PROD_W-1:0] prod,
  output logic [WIDTH-1:0]  res
);

  localparam int unsigned     UPPER_W = PROD_W - WIDTH + 1;
  localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

  logic [PROD_W-1:0]  wide;
  logic [UPPER_W-1:0] upper;
  logic               fits;
  logic [WIDTH-1:0]   clamp;

  // Kernel select: the sum is sign-extended to the product width so one
  // saturator serves both paths.
  assign wide  = use_mul ? prod : {{(PROD_W-SUM_W){sum[SUM_W-1]}}, sum};

  // Value fits when every bit from the result sign upward is equal.
  assign upper = wide[PROD_W-1:WIDTH-1];
  assign fits  = (&upper) | ~(|upper);
  assign clamp = wide[PROD_W-1] ? NEG_LIM : POS_LIM;

  assign res   = (sat_en && !fits) ? clamp : wide[WIDTH-1:0];

  always_comb begin
    if (!$isunknown({use_mul, sat_en, sum, prod})) begin
      if (sat_en) begin
        AST_SAT_SIGN: assert (res[WIDTH-1] == (use_mul ? prod[PROD_W-1] : sum[SUM_W-1]))
          else $error("saturated result changed sign"); // R6
      end
      if (sat_en && !fits) begin
        AST_SAT_CLAMP: assert (res == POS_LIM || res == NEG_LIM)
          else $error("overflow not clamped to a limit"); // R6
      end
    end
  end

endmodule

// File: rtl/shared_arith_unit.sv
module shared_arith_unit
  import sau_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [WIDTH-1:0]  opnd_c,
  input  logic [WIDTH-1:0]  opnd_d,
  output logic [WIDTH-1:0]  result,
  output logic              out_valid
);

  localparam int unsigned SUM_W  = WIDTH + 1;
  localparam int unsigned PROD_W = 2 * WIDTH;

  sau_ctrl_t         cw;
  logic [WIDTH-1:0]  op_x;
  logic [WIDTH-1:0]  op_y;
  logic [SUM_W-1:0]  k_sum;
  logic [PROD_W-1:0] k_prod;
  logic [WIDTH-1:0]  post_res;
  logic [WIDTH-1:0]  result_q;
  logic              valid_q;

  assign cw = sau_ctrl_t'(ctrl);

  sau_opsel #(.WIDTH(WIDTH)) u_opsel (
    .pick_b (cw.pick_b),
    .pick_d (cw.pick_d),
    .in_a   (opnd_a),
    .in_b   (opnd_b),
    .in_c   (opnd_c),
    .in_d   (opnd_d),
    .op_x   (op_x),
    .op_y   (op_y)
  );

  sau_kernel #(.WIDTH(WIDTH), .SUM_W(SUM_W), .PROD_W(PROD_W)) u_kernel (
    .op_x (op_x),
    .op_y (op_y),
    .sum  (k_sum),
    .prod (k_prod)
  );

  sau_post #(.WIDTH(WIDTH), .SUM_W(SUM_W), .PROD_W(PROD_W)) u_post (
    .use_mul (cw.use_mul),
    .sat_en  (cw.sat_en),
    .sum     (k_sum),
    .prod    (k_prod),
    .res     (post_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= post_res;
      end
    end
  end

  assign result    = result_q;
  assign out_valid = valid_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("out_valid missing"); // R7

  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("out_valid without input"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)) else $error("result changed while idle"); // R7

endmodule

// File: tb/tb_shared_arith_unit.sv
module tb_shared_arith_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  // {ctrl, a, b, c, d, expected}
  localparam logic [83:0] VEC [NVEC] = '{
    {4'h0, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h0008},  // R1 R2 R3 A+C
    {4'h1, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h0003},  // R1 B+C
    {4'h2, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h000A},  // R2 A+D
    {4'h3, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h0005},  // B+D
    {4'h4, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h000F},  // R3 A*C
    {4'h5, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'hFFF6},  // B*C
    {4'h6, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'h0015},  // A*D
    {4'h7, 16'h0003, 16'hFFFE, 16'h0005, 16'h0007, 16'hFFF2},  // B*D
    {4'h0, 16'h7FFF, 16'h0000, 16'h0001, 16'h0000, 16'h8000},  // R4 wrap
    {4'h8, 16'h7FFF, 16'h0000, 16'h0001, 16'h0000, 16'h7FFF},  // R6 clamp +
    {4'h8, 16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 16'h8000},  // R6 clamp -
    {4'h0, 16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 16'h7FFF},  // R4 wrap -
    {4'h4, 16'h0100, 16'h0000, 16'h0100, 16'h0000, 16'h0000},  // R5 low bits
    {4'hC, 16'h0100, 16'h0000, 16'h0100, 16'h0000, 16'h7FFF},  // R6
    {4'hC, 16'h0100, 16'h0000, 16'hFF00, 16'h0000, 16'h8000},  // R6
    {4'hC, 16'h0010, 16'h0000, 16'hFFF0, 16'h0000, 16'hFF00},  // R6 in range
    {4'hD, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h7FFF},  // R6 B*C
    {4'h6, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h0006},  // A*D
    {4'h9, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h8000},  // R6 B+C
    {4'h1, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h0000},  // R4
    {4'hA, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h0005},  // R6 A+D
    {4'hF, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h8000},  // R6 B*D
    {4'hE, 16'h0002, 16'h8000, 16'h8000, 16'h0003, 16'h0006}   // R6 A*D
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  ctrl = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, opnd_d = '0;
  logic [15:0] result;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shared_arith_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_d(opnd_d),
    .result(result), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] c, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] cc, input logic [15:0] d);
    in_valid = v; ctrl = c; opnd_a = a; opnd_b = b; opnd_c = cc; opnd_d = d;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R8 reset result", result, 16'h0000);
    check("R8 reset out_valid", {15'b0, out_valid}, 16'h0000);
    rst = 1'b0;

    // Table walk; back-to-back operations, one per cycle.
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i][83:80], VEC[i][79:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:16]);
      @(negedge clk);
      if (VEC[i][83]) tag = "R6";
      else if (VEC[i][82]) tag = "R5";
      else tag = "R4";
      if (i < 8) tag = {tag, " R1 R2 R3"};
      check($sformatf("%s vector %0d", tag, i), result, VEC[i][15:0]);
      check($sformatf("R7 valid vector %0d", i), {15'b0, out_valid}, 16'h0001);
    end

    // R7: idle input with different operands leaves the result alone.
    drive(1'b0, 4'h0, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    @(negedge clk);
    check("R7 idle out_valid low", {15'b0, out_valid}, 16'h0000);
    check("R7 idle result held", result, 16'h0006);
    @(negedge clk);
    check("R7 idle result held 2", result, 16'h0006);

    // R7: single pulse gives exactly one valid cycle.
    drive(1'b1, 4'h0, 16'h0001, 16'h0000, 16'h0002, 16'h0000);
    @(negedge clk);
    check("R7 pulse result", result, 16'h0003);
    check("R7 pulse valid", {15'b0, out_valid}, 16'h0001);
    drive(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R7 pulse valid drop", {15'b0, out_valid}, 16'h0000);
    check("R7 pulse result held", result, 16'h0003);

    // R8: reset wins over a valid input.
    drive(1'b1, 4'h4, 16'h0007, 16'h0000, 16'h0007, 16'h0000);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset over valid result", result, 16'h0000);
    check("R8 reset over valid out_valid", {15'b0, out_valid}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R5 after reset A*C", result, 16'h0031);
    check("R7 after reset valid", {15'b0, out_valid}, 16'h0001);
    drive(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule